// File: doc/BRIEF.md
# Prescaled Watchdog with Sleep Wake-up

This block is a watchdog counter that advances on a slow free-running tick, not on the processor clock. It keeps counting while the core sleeps. Software can route a power-of-two prescaler, from 1:1 up to 1:128, in front of the counter. It does so through an assign bit and a 3-bit ratio select. A clear command restarts both the counter and the prescaler. A sleep-entry command does the same, so the whole period is available before a wake. If neither command arrives in time, the block times out. While awake, a timeout raises a device-reset pulse. While asleep, it raises a wake-reset pulse instead. A timeout status bit drops to 0 on every timeout, and either command sets it back to 1. A configuration enable bit held at 0 keeps the watchdog switched off.

Everything is clocked on `clk`. The slow tick arrives as a one-cycle enable strobe. The base period `BASE_TICKS`, which must be 2 or more, is a parameter, so a short period can be used for tests. A control state machine has five states:
- `WD_OFF`: disabled.
- `WD_WATCH`: counting while awake.
- `WD_DOZE`: counting while asleep.
- `WD_BARK`: device-reset pulse.
- `WD_ROUSE`: wake-reset pulse.

The transitions are:
- Any state goes to `WD_OFF` when enable is low.
- `WD_OFF` goes to `WD_WATCH` or `WD_DOZE`, chosen by the sleep flag, when enable is high.
- `WD_WATCH` and `WD_DOZE` follow the sleep flag into each other.
- `WD_WATCH` and `WD_DOZE` go to `WD_BARK` on a timeout while awake, or to `WD_ROUSE` on a timeout while asleep.
- `WD_BARK` and `WD_ROUSE` always return after one cycle to `WD_WATCH` or `WD_DOZE`, chosen by the sleep flag.

Top module: `wdt_sleepwake`

## Requirements
- R1: After reset, `to_flag` is 1 and both `dev_rst` and `wake_rst` are 0.
- R2: With `pre_to_wdt` = 0, a timeout occurs on the `BASE_TICKS`-th tick after the last restart, whatever the value of `pre_sel`.
- R3: With `pre_to_wdt` = 1, a timeout occurs on tick number `BASE_TICKS` × 2^`pre_sel` after the last restart. The value of `pre_sel` is the base-2 exponent of the ratio: 0 gives 1:1 and 7 gives 1:128.
- R4: A timeout while `asleep` = 0 raises `dev_rst` for exactly one clock cycle. The pulse starts at the clock edge that samples the final tick, and `wake_rst` stays 0.
- R5: A timeout while `asleep` = 1 raises `wake_rst` for exactly one clock cycle, with the same timing, and `dev_rst` stays 0. The two pulses never coincide.
- R6: A `clr_cmd` strobe restarts both the counter and the prescaler, so the next timeout needs a full period of ticks.
- R7: A `sleep_cmd` strobe restarts the counter and the prescaler in the same way as `clr_cmd`.
- R8: A tick sampled in the same cycle as `clr_cmd` or `sleep_cmd` is discarded and cannot cause a timeout.
- R9: `to_flag` drops to 0 at every timeout and returns to 1 one cycle after a `clr_cmd` or `sleep_cmd` strobe.
- R10: After a timeout the counting restarts from zero, and the next timeout follows after one more full period.
- R11: While `wd_enable` = 0, no pulse is produced on either output and `to_flag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe from the slow watchdog oscillator |
| clr_cmd | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe |
| asleep | input | 1 | High while the core is sleeping |
| wd_enable | input | 1 | Configuration enable; 0 switches the watchdog off |
| pre_to_wdt | input | 1 | 1 routes the prescaler to the watchdog |
| pre_sel | input | 3 | Prescale exponent: the ratio is 1:2^pre_sel |
| dev_rst | output | 1 | One-cycle device-reset pulse on an awake timeout |
| wake_rst | output | 1 | One-cycle wake-reset pulse on an asleep timeout |
| to_flag | output | 1 | Timeout status: 0 after a timeout, 1 after a restart |

## Verification
A prescaler that holds a stale remainder after a restart shows at once as a timeout that arrives too soon. The bench measures that early arrival in ticks after a partial count followed by a clear. A wrong terminal count in either counter shifts the pulse by at least one tick in the period sweep, so the fault shows on the very first timeout. A state register stuck in a pulse state, or one that picks the wrong sleep branch, shows one cycle later: a pulse that does not fall, or a pulse on the wrong output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        WD_OFF   = 3'd0,
        WD_WATCH = 3'd1,
        WD_DOZE  = 3'd2,
        WD_BARK  = 3'd3,
        WD_ROUSE = 3'd4
    } wd_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                assign_en,
    input  logic [PRE_BITS-1:0] sel,
    input  logic                restart,
    input  logic                enable,
    output logic                step
);
    localparam int PRE_W = (1 << PRE_BITS) - 1;

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;
    logic             at_end;

    // Terminal value of the divider is 2^sel - 1.
    always_comb begin
        mask   = PRE_W'((32'd1 << sel) - 32'd1);
        at_end = (div_q >= mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || !enable || !assign_en) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= at_end ? '0 : div_q + 1'b1;
        end
    end

    assign step = enable && tick && (!assign_en || at_end);
endmodule

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
    parameter int BASE_TICKS = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    input  logic enable,
    output logic expire
);
    localparam int CNT_W = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = enable && !restart && step && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || restart || expire) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic asleep,
    input  logic enable,
    input  logic restart,
    output logic dev_rst,
    output logic wake_rst,
    output logic to_flag
);
    wd_state_e cur_q, nxt;
    wd_state_e run_st;

    assign run_st = asleep ? WD_DOZE : WD_WATCH;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= WD_OFF;
        else        cur_q <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            WD_OFF: begin
                if (enable) nxt = run_st;
            end
            WD_WATCH, WD_DOZE: begin
                if (expire) nxt = asleep ? WD_ROUSE : WD_BARK;
                else        nxt = run_st;
            end
            WD_BARK, WD_ROUSE: begin
                nxt = run_st;
            end
            default: nxt = WD_OFF;
        endcase
        if (!enable) nxt = WD_OFF;
    end

    // Outputs
    always_comb begin
        dev_rst  = (cur_q == WD_BARK);
        wake_rst = (cur_q == WD_ROUSE);
    end

    // Timeout status bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       to_flag <= 1'b1;
        else if (restart) to_flag <= 1'b1;
        else if (expire)  to_flag <= 1'b0;
    end
endmodule

// File: rtl/wdt_sleepwake.sv
module wdt_sleepwake #(
    parameter int BASE_TICKS = 18,
    parameter int PRE_BITS   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                clr_cmd,
    input  logic                sleep_cmd,
    input  logic                asleep,
    input  logic                wd_enable,
    input  logic                pre_to_wdt,
    input  logic [PRE_BITS-1:0] pre_sel,
    output logic                dev_rst,
    output logic                wake_rst,
    output logic                to_flag
);
    logic restart;
    logic step;
    logic expire;

    assign restart = clr_cmd || sleep_cmd;

    wdt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .assign_en (pre_to_wdt),
        .sel       (pre_sel),
        .restart   (restart),
        .enable    (wd_enable),
        .step      (step)
    );

    wdt_base_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .restart (restart),
        .enable  (wd_enable),
        .expire  (expire)
    );

    wdt_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .asleep   (asleep),
        .enable   (wd_enable),
        .restart  (restart),
        .dev_rst  (dev_rst),
        .wake_rst (wake_rst),
        .to_flag  (to_flag)
    );
endmodule

// File: rtl/wdt_sleepwake_chk.sv
module wdt_sleepwake_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic clr_cmd,
    input logic sleep_cmd,
    input logic wd_enable,
    input logic dev_rst,
    input logic wake_rst,
    input logic to_flag
);
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rst && wake_rst)); // R5
    AST_DEV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> !dev_rst); // R4
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |=> !wake_rst); // R5
    AST_FLAG_LOW_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst || wake_rst) |-> !to_flag); // R9
    AST_RESTART_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd || sleep_cmd) |=> to_flag); // R9
    AST_RESTART_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd || sleep_cmd) |=> !(dev_rst || wake_rst)); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !(dev_rst || wake_rst)); // R11
    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst || wake_rst) |-> $past(tick)); // R2
endmodule

bind wdt_sleepwake wdt_sleepwake_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr_cmd   (clr_cmd),
    .sleep_cmd (sleep_cmd),
    .wd_enable (wd_enable),
    .dev_rst   (dev_rst),
    .wake_rst  (wake_rst),
    .to_flag   (to_flag)
);

// File: tb/wdt_sleepwake_test.sv
module wdt_sleepwake_test;
    localparam int BASE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, clr_cmd = 1'b0, sleep_cmd = 1'b0, asleep = 1'b0;
    logic       wd_enable = 1'b1, pre_to_wdt = 1'b0;
    logic [2:0] pre_sel = 3'd0;
    logic       dev_rst, wake_rst, to_flag;

    int  total = 0, bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    wdt_sleepwake #(.BASE_TICKS(BASE), .PRE_BITS(3)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr_cmd(clr_cmd),
        .sleep_cmd(sleep_cmd), .asleep(asleep), .wd_enable(wd_enable),
        .pre_to_wdt(pre_to_wdt), .pre_sel(pre_sel),
        .dev_rst(dev_rst), .wake_rst(wake_rst), .to_flag(to_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply n ticks; count pulses seen right after each consuming edge.
    task automatic ticks(input int n, output int nd, output int nw);
        nd = 0; nw = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            nd += int'(dev_rst);
            nw += int'(wake_rst);
        end
    endtask

    task automatic restart_cmd(input bit use_sleep);
        @(negedge clk);
        if (use_sleep) sleep_cmd = 1'b1; else clr_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0; clr_cmd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nd, nw, per;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(to_flag == 1'b1, "R1 flag", int'(to_flag), 1);
        chk(!dev_rst && !wake_rst, "R1 pulses", int'(dev_rst | wake_rst), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep: assign off/on, every select, awake/asleep (R2 R3 R4 R5 R9 R10)
        for (int asg = 0; asg < 2; asg++) begin
            for (int s = 0; s < 8; s++) begin
                for (int slp = 0; slp < 2; slp++) begin
                    pre_to_wdt = asg[0];
                    pre_sel    = 3'(s);
                    asleep     = slp[0];
                    per = asg ? (BASE << s) : BASE;
                    restart_cmd(slp[0]);
                    chk(to_flag, "R9 flag set by restart", int'(to_flag), 1);
                    ticks(per - 1, nd, nw);
                    chk(nd + nw == 0, asg ? "R3 early pulse" : "R2 early pulse", nd + nw, 0);
                    ticks(1, nd, nw);
                    if (slp) chk(nw == 1 && nd == 0, "R5 wake pulse", nw * 10 + nd, 10);
                    else     chk(nd == 1 && nw == 0, "R4 reset pulse", nd * 10 + nw, 10);
                    chk(!to_flag, "R9 flag cleared", int'(to_flag), 0);
                    @(negedge clk);
                    chk(!dev_rst && !wake_rst, slp ? "R5 width" : "R4 width",
                        int'(dev_rst | wake_rst), 0);
                    // R10: second period after the timeout
                    ticks(per - 1, nd, nw);
                    chk(nd + nw == 0, "R10 early second pulse", nd + nw, 0);
                    ticks(1, nd, nw);
                    chk(nd + nw == 1, "R10 second pulse", nd + nw, 1);
                end
            end
        end

        // R6: clear mid-count restarts counter and prescaler (ratio 1:4)
        asleep = 1'b0; pre_to_wdt = 1'b1; pre_sel = 3'd2;
        restart_cmd(1'b0);
        ticks(3, nd, nw);
        restart_cmd(1'b0);
        ticks(BASE * 4 - 1, nd, nw);
        chk(nd + nw == 0, "R6 prescaler cleared", nd + nw, 0);
        ticks(1, nd, nw);
        chk(nd == 1, "R6 full period after clear", nd, 1);

        // R7: sleep entry restarts the same way
        asleep = 1'b1;
        restart_cmd(1'b1);
        ticks(BASE * 4 - 2, nd, nw);
        restart_cmd(1'b1);
        ticks(BASE * 4 - 1, nd, nw);
        chk(nd + nw == 0, "R7 sleep restart", nd + nw, 0);
        ticks(1, nd, nw);
        chk(nw == 1, "R7 wake after full period", nw, 1);

        // R8: tick coincident with clear is discarded
        asleep = 1'b0; pre_to_wdt = 1'b0;
        restart_cmd(1'b0);
        ticks(BASE - 1, nd, nw);
        @(negedge clk) begin tick = 1'b1; clr_cmd = 1'b1; end
        @(negedge clk) begin tick = 1'b0; clr_cmd = 1'b0; end
        chk(!dev_rst && !wake_rst, "R8 no pulse with clear", int'(dev_rst | wake_rst), 0);
        ticks(BASE - 1, nd, nw);
        chk(nd + nw == 0, "R8 tick discarded", nd + nw, 0);
        ticks(1, nd, nw);
        chk(nd == 1, "R8 timeout after full period", nd, 1);

        // R11: disabled watchdog stays quiet and keeps the flag
        restart_cmd(1'b0);
        wd_enable = 1'b0; pre_to_wdt = 1'b1; pre_sel = 3'd0;
        ticks(40, nd, nw);
        chk(nd + nw == 0, "R11 no pulse while disabled", nd + nw, 0);
        chk(to_flag, "R11 flag kept", int'(to_flag), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule